// File: doc/BRIEF.md
# I2C Master Command and Transmit Engine

This block is the transmit half of an I2C bus master. Software drives it through a small
register port: a control register requests a START, a repeated START or a STOP and holds
the core enable; a data register either sends one byte at once or, when the transmit
queue is switched on, pushes the byte into a 64-entry queue. The queue drains on its own,
one byte after the other. Each byte goes out most significant bit first. The engine then
releases SDA for a ninth clock and samples the acknowledge from the target.

A status register holds four indications: busy, session done, transmit queue empty and
NAK received. The last three are cleared by writing ones. An interrupt line combines them
with per-bit enables. Both bus lines are open-drain. The block only drives output enables
that pull a line low, and reads the resolved SDA level back. A NAK freezes the queue until
software flushes it.

Top module: `i2c_cmd_tx`

## Requirements
- R1: After reset both line enables are low (lines released), the interrupt is low, and the control register (address 0) and the status register (address 2) read 0.
- R2: A write to control with bit 0 = 1 and bits [2:1] = 1 issues a START when bit 3 = 0 and a repeated START when bit 3 = 1. Bits [2:1] = 2 issue a STOP, and 0 or 3 issue nothing. Bit 0 is stored as the core enable, and a write with bit 0 = 0 issues no bus condition. The lines change only while a bus condition or byte is executing.
- R3: Status bit 7 (busy) is high while a condition or byte is executing or the queue is ready to drain. A control write made while busy is high is ignored. So is a data write (address 1) made while busy is high with the queue disabled.
- R4: A data write with the queue disabled and the core enabled sends the byte MSB first on 8 SCL pulses. SDA is released on a 9th pulse, and the acknowledge is sampled at the end of that pulse's high phase.
- R5: Control bit 3 reads 1 if the most recently sent byte was NAKed and 0 if it was ACKed.
- R6: Status bit 3 (session done) is set when a bus condition or a single directly written byte completes. Bytes drained from the queue do not set it.
- R7: Status bit 0 is set when a sent byte is NAKed.
- R8: Writing 1 to a status bit at address 2 clears it, and writing 0 leaves it. Bits 2 and 4 always read 0.
- R9: The interrupt enable register (address 3) keeps bits 0, 1, 3 and 4 and reads bits 2 and 5 to 7 as 0. The interrupt is high exactly when some status bit among 0 to 4 and its enable are both 1.
- R10: Queue control (address 4) bit 6 enables the queue. With it set, data writes push bytes, which are sent in write order while the core is enabled. Status bit 1 is set when a queued byte completes with an ACK and the queue is empty.
- R11: The queue holds 64 bytes, and a push into a full queue is dropped.
- R12: After a NAK the queue stops draining, even when more bytes are pushed. A write to queue control with bit 7 = 1 discards the queued bytes and lets draining resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for `addr` (combinational) |
| sda_in | input | 1 | Resolved SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest state to reach is a NAK in the middle of a queued burst. Bytes are still queued and the engine is idle yet must not resume. A bus model in the bench follows SCL and SDA, rebuilds every byte, and withholds the acknowledge for one chosen byte index. That lets a burst be NAKed on its second byte. Further pushes then show the queue frozen, until a flush and one more byte show it resuming. The full-queue case is reached by loading the queue while the core is disabled, so nothing drains, and then enabling it.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN  = 3'd3;
    localparam logic [ADDR_W-1:0] A_QCTL = 3'd4;

    localparam logic [4:0] IEN_KEEP = 5'b11011;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_BEGIN = 2'd1,
        OP_END   = 2'd2,
        OP_IDLE3 = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        K_START,
        K_RESTART,
        K_STOP,
        K_BYTE
    } act_kind_e;

    typedef struct packed {
        logic sd;
        logic txe;
        logic nak;
    } stat_t;

    function automatic logic [7:0] stat_byte(stat_t s, logic busy);
        return {busy, 2'b00, 1'b0, s.sd, 1'b0, s.txe, s.nak};
    endfunction

endpackage

// File: rtl/i2ct_fifo.sv
module i2ct_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          full, do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/i2ct_bitgen.sv
module i2ct_bitgen
    import i2ct_pkg::*;
#(
    parameter int QTR = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      go,
    input  act_kind_e kind,
    input  logic [7:0] byte_in,
    input  logic      sda_in,
    output logic      busy,
    output logic      done,
    output logic      nak,
    output logic      scl_oe,
    output logic      sda_oe
);
    localparam int QW        = (QTR > 1) ? $clog2(QTR) : 1;
    localparam int LAST_COND = 3;
    localparam int LAST_BYTE = 9 * 4 - 1;
    localparam int SW        = $clog2(LAST_BYTE + 1);

    logic [QW-1:0] qcnt;
    logic [SW-1:0] step;
    act_kind_e     kind_q;
    logic [7:0]    sh;
    logic          busy_q, scl_q, sda_q;
    logic          tick, last_step;
    logic          scl_n, sda_n;
    logic [3:0]    bitn;
    logic [1:0]    ph;

    assign tick      = busy_q && (qcnt == QW'(QTR - 1));
    assign last_step = (kind_q == K_BYTE) ? (step == SW'(LAST_BYTE))
                                          : (step == SW'(LAST_COND));
    assign done   = tick && last_step;
    assign nak    = sda_in;
    assign busy   = busy_q;
    assign scl_oe = scl_q;
    assign sda_oe = sda_q;

    always_comb begin
        bitn  = step[SW-1:2];
        ph    = step[1:0];
        scl_n = scl_q;
        sda_n = sda_q;
        unique case (kind_q)
            K_START: begin
                scl_n = (step == SW'(3));
                sda_n = (step >= SW'(2));
            end
            K_RESTART: begin
                scl_n = (step == SW'(0)) || (step == SW'(3));
                sda_n = (step >= SW'(2));
            end
            K_STOP: begin
                scl_n = (step == SW'(0));
                sda_n = (step <= SW'(1));
            end
            K_BYTE: begin
                scl_n = (ph < 2'd2);
                if (ph == 2'd0)       sda_n = sda_q;
                else if (bitn < 4'd8) sda_n = ~sh[3'd7 - bitn[2:0]];
                else                  sda_n = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            qcnt   <= '0;
            step   <= '0;
            kind_q <= K_STOP;
            sh     <= '0;
            scl_q  <= 1'b0;
            sda_q  <= 1'b0;
        end else begin
            if (!busy_q) begin
                if (go) begin
                    busy_q <= 1'b1;
                    kind_q <= kind;
                    sh     <= byte_in;
                    qcnt   <= '0;
                    step   <= '0;
                end
            end else begin
                qcnt <= tick ? '0 : qcnt + 1'b1;
                if (tick) begin
                    if (last_step) busy_q <= 1'b0;
                    else           step   <= step + 1'b1;
                end
                scl_q <= scl_n;
                sda_q <= sda_n;
            end
        end
    end
endmodule

// File: rtl/i2c_cmd_tx.sv
module i2c_cmd_tx
    import i2ct_pkg::*;
#(
    parameter int QTR        = 4,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              irq
);
    logic      en_q, ack_q, qen_q, nak_hold;
    logic      cur_fifo, cur_byte;
    stat_t     st;
    logic [4:0] ien_q;

    logic      wr_ctrl, wr_data, wr_stat, wr_ien, wr_qctl;
    logic      drain_rdy, busy_flag, cmd_go, single_go;
    logic      fifo_push, fifo_pop, fifo_flush, fifo_empty;
    logic [7:0] fifo_dout;
    logic      phy_go, phy_busy, phy_done, phy_nak;
    act_kind_e phy_kind;
    logic [7:0] phy_byte, stat_rd;
    bus_op_e   op;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_data = wr_en && (addr == A_DATA);
    assign wr_stat = wr_en && (addr == A_STAT);
    assign wr_ien  = wr_en && (addr == A_IEN);
    assign wr_qctl = wr_en && (addr == A_QCTL);

    assign op         = bus_op_e'(wdata[2:1]);
    assign drain_rdy  = qen_q && en_q && !fifo_empty && !nak_hold;
    assign busy_flag  = phy_busy || drain_rdy;
    assign cmd_go     = wr_ctrl && !busy_flag && wdata[0]
                        && ((op == OP_BEGIN) || (op == OP_END));
    assign single_go  = wr_data && !qen_q && !busy_flag && en_q;
    assign fifo_push  = wr_data && qen_q;
    assign fifo_pop   = drain_rdy && !phy_busy;
    assign fifo_flush = wr_qctl && wdata[7];

    assign phy_go   = cmd_go || single_go || fifo_pop;
    assign phy_byte = fifo_pop ? fifo_dout : wdata;
    always_comb begin
        if (!cmd_go)             phy_kind = K_BYTE;
        else if (op == OP_END)   phy_kind = K_STOP;
        else if (wdata[3])       phy_kind = K_RESTART;
        else                     phy_kind = K_START;
    end

    i2ct_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (fifo_flush),
        .push  (fifo_push),
        .din   (wdata),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .empty (fifo_empty)
    );

    i2ct_bitgen #(.QTR(QTR)) u_phy (
        .clk     (clk),
        .rst     (rst),
        .go      (phy_go),
        .kind    (phy_kind),
        .byte_in (phy_byte),
        .sda_in  (sda_in),
        .busy    (phy_busy),
        .done    (phy_done),
        .nak     (phy_nak),
        .scl_oe  (scl_oe),
        .sda_oe  (sda_oe)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            ack_q    <= 1'b0;
            qen_q    <= 1'b0;
            nak_hold <= 1'b0;
            cur_fifo <= 1'b0;
            cur_byte <= 1'b0;
            st       <= '0;
            ien_q    <= '0;
        end else begin
            if (wr_ctrl && !busy_flag) en_q <= wdata[0];
            if (wr_ien)  ien_q <= wdata[4:0] & IEN_KEEP;
            if (wr_qctl) qen_q <= wdata[6];

            if (phy_go) begin
                cur_fifo <= fifo_pop;
                cur_byte <= !cmd_go;
            end

            // status: a new event wins over a clear in the same cycle
            st.nak <= st.nak & ~(wr_stat & wdata[0]);
            st.txe <= st.txe & ~(wr_stat & wdata[1]);
            st.sd  <= st.sd  & ~(wr_stat & wdata[3]);
            if (phy_done) begin
                if (cur_byte) begin
                    ack_q <= phy_nak;
                    if (phy_nak) st.nak <= 1'b1;
                end
                if (!cur_fifo) st.sd <= 1'b1;
                if (cur_fifo && fifo_empty && !phy_nak) st.txe <= 1'b1;
            end

            if (fifo_flush)                                   nak_hold <= 1'b0;
            else if (phy_done && cur_byte && cur_fifo && phy_nak) nak_hold <= 1'b1;
        end
    end

    assign stat_rd = stat_byte(st, busy_flag);
    assign irq     = |(stat_rd[4:0] & ien_q);

    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = {4'b0000, ack_q, 2'b00, en_q};
            A_STAT:  rdata = stat_rd;
            A_IEN:   rdata = {3'b000, ien_q};
            A_QCTL:  rdata = {1'b0, qen_q, 6'b000000};
            default: rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       en_q,
    input logic       busy_flag,
    input logic       phy_busy,
    input logic       phy_done,
    input logic       nak_hold,
    input logic       fifo_pop
);
    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!scl_oe && !sda_oe));

    // R2
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (!phy_busy && !$past(phy_busy)) |-> ($stable(scl_oe) && $stable(sda_oe)));

    // R3
    ctrl_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (addr == 3'd0) && busy_flag) |=> $stable(en_q));

    // R4
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        phy_done |=> !phy_busy);

    // R12
    hold_no_pop_chk: assert property (@(posedge clk) disable iff (rst)
        nak_hold |-> !fifo_pop);
endmodule

bind i2c_cmd_tx i2ct_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .en_q      (en_q),
    .busy_flag (busy_flag),
    .phy_busy  (phy_busy),
    .phy_done  (phy_done),
    .nak_hold  (nak_hold),
    .fifo_pop  (fifo_pop)
);

// File: tb/sim_i2c_cmd_tx.sv
`timescale 1ns/1ps
module sim_i2c_cmd_tx;
    import i2ct_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       sda_in, scl_oe, sda_oe, irq;
    logic       slave_pull = 1'b0;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign sda_in = ~(sda_oe | slave_pull);

    i2c_cmd_tx u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    // bus model: rebuilds bytes, counts conditions, acknowledges
    logic [7:0] mon [256];
    int mon_n = 0, n_start = 0, n_stop = 0, bitc = 0, nak_at = -1;
    logic [7:0] msh = 8'h00;
    logic scl_p = 1'b1, sda_p = 1'b1;
    always @(posedge clk) begin
        logic scl_l, sda_l;
        scl_l = ~scl_oe;
        sda_l = sda_in;
        if (!rst) begin
            if (scl_l && scl_p && sda_p && !sda_l) begin n_start++; bitc = 0; end
            else if (scl_l && scl_p && !sda_p && sda_l) n_stop++;
            if (scl_l && !scl_p) begin
                if (bitc < 8) begin msh = {msh[6:0], sda_l}; bitc++; end
                else begin mon[mon_n[7:0]] = msh; mon_n++; bitc = 0; end
            end
            if (!scl_l && scl_p) slave_pull = (bitc == 8) && (mon_n != nak_at);
        end
        scl_p = scl_l;
        sda_p = sda_l;
    end

    function automatic logic [7:0] exp_stat(bit nk, bit te, bit sd);
        return {4'b0000, sd, 1'b0, te, nk};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int k = 0;
        rd(A_STAT, s);
        while (s[7] && k < 30000) begin rd(A_STAT, s); k++; end
        repeat (8) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
    end

    initial begin
        logic [7:0] d, b;
        logic [7:0] q [66];
        int base, s0, p0;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(A_CTRL, d); chk("R1 ctrl", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
        chk("R1 irq", irq, 0);
        chk("R1 lines", {scl_oe, sda_oe}, 0);

        // R2 command with enable clear does nothing
        wr(A_CTRL, 8'h02);
        repeat (40) @(negedge clk);
        chk("R2 disabled start", n_start, 0);
        rd(A_STAT, d); chk("R2 disabled busy", d[7], 0);

        // R2 START, R3 busy, R6 session done
        wr(A_CTRL, 8'h03);
        rd(A_STAT, d); chk("R3 busy during start", d[7], 1);
        wait_idle();
        chk("R2 start seen", n_start, 1);
        rd(A_STAT, d); chk("R6 sd after start", d, exp_stat(0, 0, 1));

        // R4 single bytes, R3 writes during busy dropped, R5 ack
        for (int i = 0; i < 6; i++) begin
            wr(A_STAT, 8'hFF);
            b = 8'($urandom);
            if (i == 0) b = 8'h80;
            if (i == 1) b = 8'h01;
            base = mon_n; s0 = n_stop;
            wr(A_DATA, b);
            wr(A_DATA, ~b);
            wr(A_CTRL, 8'h05);
            wait_idle();
            chk("R3 one byte only", mon_n - base, 1);
            chk("R3 stop ignored", n_stop - s0, 0);
            chk("R4 byte msb first", mon[base[7:0]], b);
            rd(A_CTRL, d); chk("R5 ack", d[3], 0);
            rd(A_STAT, d); chk("R6 sd after byte", d, exp_stat(0, 0, 1));
        end

        // R7 NAK, R5 NAK flag, R9 interrupt, R8 clearing
        wr(A_STAT, 8'hFF);
        nak_at = mon_n;
        wr(A_DATA, 8'hA5);
        wait_idle();
        nak_at = -1;
        rd(A_CTRL, d); chk("R5 nak flag", d[3], 1);
        rd(A_STAT, d); chk("R7 nak status", d, exp_stat(1, 0, 1));
        wr(A_IEN, 8'h08); @(negedge clk); chk("R9 irq sd", irq, 1);
        wr(A_IEN, 8'h02); @(negedge clk); chk("R9 irq masked", irq, 0);
        wr(A_IEN, 8'h01); @(negedge clk); chk("R9 irq nak", irq, 1);
        wr(A_STAT, 8'h01);
        rd(A_STAT, d); chk("R8 clear nak only", d, exp_stat(0, 0, 1));
        chk("R9 irq after clear", irq, 0);
        wr(A_IEN, 8'hFF); rd(A_IEN, d); chk("R9 enable readback", d, 8'h1B);
        wr(A_STAT, 8'hFF); rd(A_STAT, d); chk("R8 clear all", d, 0);
        wr(A_IEN, 8'h00);

        // R2 repeated START and STOP
        s0 = n_start; p0 = n_stop;
        wr(A_CTRL, 8'h0B); wait_idle();
        chk("R2 restart", n_start - s0, 1);
        wr(A_CTRL, 8'h05); wait_idle();
        chk("R2 stop", n_stop - p0, 1);
        wr(A_CTRL, 8'h07); repeat (40) @(negedge clk);
        chk("R2 opcode 3 idle", n_stop - p0 + n_start - s0, 2);

        // R10 queue burst
        wr(A_QCTL, 8'hC0);
        wr(A_CTRL, 8'h03); wait_idle();
        wr(A_STAT, 8'hFF);
        base = mon_n;
        for (int i = 0; i < 5; i++) begin q[i] = 8'($urandom); wr(A_DATA, q[i]); end
        wait_idle();
        chk("R10 burst count", mon_n - base, 5);
        for (int i = 0; i < 5; i++) chk("R10 burst order", mon[8'(base + i)], q[i]);
        rd(A_STAT, d); chk("R10 txe, R6 no sd", d, exp_stat(0, 1, 0));

        // R12 NAK freezes the queue, flush resumes
        wr(A_STAT, 8'hFF);
        base = mon_n;
        nak_at = mon_n + 1;
        for (int i = 0; i < 4; i++) begin q[i] = 8'($urandom); wr(A_DATA, q[i]); end
        wait_idle();
        nak_at = -1;
        chk("R12 stop after nak", mon_n - base, 2);
        rd(A_STAT, d); chk("R12 nak flagged", d[0], 1);
        wr(A_DATA, 8'h3C);
        repeat (400) @(negedge clk);
        chk("R12 frozen", mon_n - base, 2);
        wr(A_QCTL, 8'hC0);
        wr(A_DATA, 8'h96);
        wait_idle();
        chk("R12 resume count", mon_n - base, 3);
        chk("R12 resume byte", mon[8'(base + 2)], 8'h96);

        // R11 full queue drops extra pushes
        wr(A_STAT, 8'hFF);
        wr(A_CTRL, 8'h00);
        base = mon_n;
        for (int i = 0; i < 66; i++) begin q[i] = 8'($urandom); wr(A_DATA, q[i]); end
        repeat (40) @(negedge clk);
        chk("R11 no drain while disabled", mon_n - base, 0);
        wr(A_CTRL, 8'h01);
        wait_idle();
        chk("R11 depth", mon_n - base, 64);
        for (int i = 0; i < 64; i++) chk("R11 content", mon[8'(base + i)], q[i]);

        summary();
    end
endmodule